// File: doc/BRIEF.md
# Stereo Counter-Phase Flanger Delay

This block is the per-sample core of a stereo flanger. It takes one mono audio sample on each strobe and stores it in an external single-port synchronous SRAM. The SRAM is used as a circular delay line, addressed by a free-running 16-bit write pointer. It then reads back two delayed taps, one for the right output and one for the left. Each tap is linearly interpolated between two neighbouring stored samples.

A 16-bit unsigned modulation word, normally an LFO value, sets the right tap's delay. Its high byte is the whole-sample delay and its low byte is the fractional weight. The left tap uses the complement word `{depth, 8'h00} - mod`. As the modulation rises, one tap's delay grows while the other's shrinks, and the ear hears this as a source moving between left and right. The block adds no fixed base delay. With depth zero and modulation zero, both taps land on the sample just written.

For each sample the block makes one SRAM write followed by four reads, one access per clock. The SRAM returns read data one clock after the read enable. A one-cycle valid pulse marks the new outputs, and the outputs hold their values between pulses.

Top module: `counterphase_flanger`

## Requirements
- R1: While reset is high, `out_left`, `out_right`, `out_valid`, `sram_we` and `sram_re` are all 0, and the write pointer is 0, so the first sample after reset is written at address 1.
- R2: An accepted strobe first adds one to the 16-bit write pointer (wrapping modulo 2^16). In the next cycle the block asserts `sram_we` and writes the strobed `in_left` value at the new pointer. `in_right` has no effect on any output.
- R3: Let W be the write pointer and M the modulation word. The right tap reads address W − M[15:8] − 1 in the cycle after the write, and address W − M[15:8] in the cycle after that (both modulo 2^16).
- R4: Let A be the sample read from the first right address, B the sample read from the second, and f = M[7:0]. Then `out_right` = (A·f + B·(255 − f)) >>> 8, where the samples are two's-complement signed, f is unsigned, and the product is exact.
- R5: The left tap uses the word L = ({depth, 8'h00} − M) mod 2^16. It reads W − L[15:8] − 1 and then W − L[15:8] in the two cycles after the right reads. `out_left` is formed with the same formula as R4, using f = L[7:0].
- R6: With depth 0 and modulation 0, both outputs equal (x·255) >>> 8, where x is the sample just strobed.
- R7: `out_valid` is a one-cycle pulse, six clocks after the edge that accepts the strobe. Both outputs change only on that pulse and hold their values otherwise.
- R8: A strobe that arrives while a sample is still in progress, including the cycle of the valid pulse edge, is ignored. It causes no write and changes no output.
- R9: `sram_we` and `sram_re` are never high in the same cycle. Each accepted sample produces exactly one write and four reads, and the bus is idle in the cycle before the valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe for a new sample |
| in_left | input | 16 | Signed mono sample that is stored |
| in_right | input | 16 | Second input channel, ignored |
| mod_word | input | 16 | Unsigned modulation: delay in high byte, fraction in low byte |
| depth | input | 8 | Modulation depth, sets the complementary left word |
| sram_addr | output | 16 | SRAM address |
| sram_we | output | 1 | SRAM write enable |
| sram_re | output | 1 | SRAM read enable |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, valid one clock after `sram_re` |
| out_left | output | 16 | Signed left output |
| out_right | output | 16 | Signed right output |
| out_valid | output | 1 | One-cycle pulse when outputs update |

## Verification
The assertions check, on every cycle, the properties that hold at any instant:
- read and write never overlap on the SRAM port;
- the write pointer only ever steps by one;
- the written data is the sample strobed one cycle earlier;
- the valid pulse lasts a single cycle;
- the outputs stay still away from that pulse;
- no new write sequence starts while a sample is in progress.

The interpolation arithmetic, the complementary left delay and the exact read addresses can only be shown by the bench's scenarios. There a behavioural history of written samples predicts every bus access and output value. These scenarios cover zero and full fractions, maximum depth, modulation above the depth span, and strobes issued while a sample is in progress.

// File: rtl/flg_pkg.sv
package flg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RA,
    ST_RB,
    ST_LA,
    ST_LB,
    ST_FIN
  } flg_state_e;
endpackage

// File: rtl/flg_seq.sv
module flg_seq
  import flg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output flg_state_e state
);
  flg_state_e nxt;

  always_comb begin
    case (state)
      ST_IDLE: nxt = start ? ST_WR : ST_IDLE;
      ST_WR:   nxt = ST_RA;
      ST_RA:   nxt = ST_RB;
      ST_RB:   nxt = ST_LA;
      ST_LA:   nxt = ST_LB;
      ST_LB:   nxt = ST_FIN;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  AST_BUSY_IGNORES_STROBE: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (state != ST_WR)); // R8
endmodule

// File: rtl/flg_tap.sv
module flg_tap #(
  parameter int ADDR_W = 16,
  parameter int MOD_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [MOD_W-1:0]  word,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic [FRAC_W-1:0] frac
);
  localparam int INT_W = MOD_W - FRAC_W;

  logic [ADDR_W-1:0] whole;

  assign whole  = ADDR_W'(word[MOD_W-1:FRAC_W]);
  assign addr_a = wr_ptr - whole - ADDR_W'(1);
  assign addr_b = addr_a + ADDR_W'(1);
  assign frac   = word[FRAC_W-1:0];

  initial begin
    AST_TAP_WIDTH: assert (INT_W > 0 && INT_W <= ADDR_W); // R3
  end
endmodule

// File: rtl/flg_mac.sv
module flg_mac #(
  parameter int SMP_W = 16,
  parameter int WT_W  = 8
) (
  input  logic [SMP_W-1:0] s_first,
  input  logic [SMP_W-1:0] s_second,
  input  logic [WT_W-1:0]  w,
  output logic [SMP_W-1:0] y
);
  localparam int PW = SMP_W + WT_W;

  logic signed [PW-1:0] e1, e2, w1, w2, sum;
  logic [WT_W-1:0] sum_lo_unused;

  assign e1  = {{WT_W{s_first[SMP_W-1]}},  s_first};
  assign e2  = {{WT_W{s_second[SMP_W-1]}}, s_second};
  assign w1  = {{SMP_W{1'b0}}, w};
  assign w2  = {{SMP_W{1'b0}}, ~w};
  assign sum = e1 * w1 + e2 * w2;
  assign {y, sum_lo_unused} = sum;
endmodule

// File: rtl/counterphase_flanger.sv
module counterphase_flanger
  import flg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SMP_W  = 16,
  parameter int MOD_W  = 16,
  parameter int DEP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic [SMP_W-1:0]  in_left,
  input  logic [SMP_W-1:0]  in_right,
  input  logic [MOD_W-1:0]  mod_word,
  input  logic [DEP_W-1:0]  depth,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_we,
  output logic              sram_re,
  output logic [SMP_W-1:0]  sram_wdata,
  input  logic [SMP_W-1:0]  sram_rdata,
  output logic [SMP_W-1:0]  out_left,
  output logic [SMP_W-1:0]  out_right,
  output logic              out_valid
);
  localparam int FRAC_W = MOD_W - DEP_W;
  localparam int NTAP   = 2;

  flg_state_e st;
  logic [ADDR_W-1:0] wr_ptr;
  logic [SMP_W-1:0]  smp_q, hold_q, rpend_q, mac_y;
  logic [MOD_W-1:0]  mod_q;
  logic [DEP_W-1:0]  dep_q;
  logic [MOD_W-1:0]  tap_word [NTAP];
  logic [ADDR_W-1:0] tap_a [NTAP];
  logic [ADDR_W-1:0] tap_b [NTAP];
  logic [FRAC_W-1:0] tap_f [NTAP];
  logic [FRAC_W-1:0] mac_w;
  logic              in_right_unused;

  assign in_right_unused = ^in_right;

  flg_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (smp_stb),
    .state (st)
  );

  // tap 0 = right (modulation), tap 1 = left (complement)
  assign tap_word[0] = mod_q;
  assign tap_word[1] = {dep_q, {FRAC_W{1'b0}}} - mod_q;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    flg_tap #(
      .ADDR_W (ADDR_W),
      .MOD_W  (MOD_W),
      .FRAC_W (FRAC_W)
    ) u_tap (
      .wr_ptr (wr_ptr),
      .word   (tap_word[g]),
      .addr_a (tap_a[g]),
      .addr_b (tap_b[g]),
      .frac   (tap_f[g])
    );
  end

  assign mac_w = (st == ST_FIN) ? tap_f[1] : tap_f[0];

  flg_mac #(
    .SMP_W (SMP_W),
    .WT_W  (FRAC_W)
  ) u_mac (
    .s_first  (hold_q),
    .s_second (sram_rdata),
    .w        (mac_w),
    .y        (mac_y)
  );

  always_comb begin
    sram_we    = (st == ST_WR);
    sram_re    = (st == ST_RA) || (st == ST_RB) || (st == ST_LA) || (st == ST_LB);
    sram_wdata = smp_q;
    case (st)
      ST_RA:   sram_addr = tap_a[0];
      ST_RB:   sram_addr = tap_b[0];
      ST_LA:   sram_addr = tap_a[1];
      ST_LB:   sram_addr = tap_b[1];
      default: sram_addr = wr_ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      smp_q     <= '0;
      mod_q     <= '0;
      dep_q     <= '0;
      hold_q    <= '0;
      rpend_q   <= '0;
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (st == ST_IDLE && smp_stb) begin
        smp_q  <= in_left;
        mod_q  <= mod_word;
        dep_q  <= depth;
        wr_ptr <= wr_ptr + ADDR_W'(1);
      end
      if (st == ST_RB || st == ST_LB) hold_q <= sram_rdata;
      if (st == ST_LA) rpend_q <= mac_y;
      if (st == ST_FIN) begin
        out_left  <= mac_y;
        out_right <= rpend_q;
        out_valid <= 1'b1;
      end
    end
  end

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(sram_we && sram_re)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_left) && $stable(out_right))); // R7
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_ptr) |-> (wr_ptr == $past(wr_ptr) + ADDR_W'(1))); // R2
  AST_WRITE_DATA: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> (sram_wdata == $past(in_left))); // R2
endmodule

// File: tb/counterphase_flanger_tb.sv
module counterphase_flanger_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_stb = 1'b0;
  logic [15:0] in_left = '0, in_right = '0, mod_word = '0;
  logic [7:0]  depth = '0;
  logic [15:0] sram_addr, sram_wdata, out_left, out_right;
  logic [15:0] sram_rdata = '0;
  logic        sram_we, sram_re, out_valid;

  always #5 clk = ~clk;

  counterphase_flanger u_dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .in_left(in_left), .in_right(in_right),
    .mod_word(mod_word), .depth(depth), .sram_addr(sram_addr), .sram_we(sram_we),
    .sram_re(sram_re), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .out_left(out_left), .out_right(out_right), .out_valid(out_valid)
  );

  // synchronous SRAM, one-cycle read latency
  logic [15:0] mem [4096];
  always @(posedge clk) begin
    if (sram_we) mem[sram_addr[11:0]] <= sram_wdata;
    if (sram_re) sram_rdata <= mem[sram_addr[11:0]];
  end

  int vectors = 0, fails = 0, sent = 0, writes = 0, reads = 0;
  bit started = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // behavioural reference: history of stored samples, newest first
  int   hist[$];
  int   ph = 0, wcount = 0, hi, fr, lw, lhi, lfr;
  int   exp_addr[5];
  int   exp_wdata;
  logic exp_valid = 0;
  logic [15:0] exp_l = 0, exp_r = 0, pend_l, pend_r;

  function automatic logic [15:0] interp(int s1, int s2, int f);
    int acc;
    acc = s1 * f + s2 * (255 - f);
    return 16'(acc >>> 8);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; wcount = 0; exp_valid = 0; exp_l = 0; exp_r = 0;
    end else begin
      exp_valid = 0;
      if (ph == 0 && smp_stb) begin
        wcount = (wcount + 1) & 16'hffff;
        hist.push_front(int'($signed(in_left)));
        if (hist.size() > 300) void'(hist.pop_back());
        hi = int'(mod_word[15:8]); fr = int'(mod_word[7:0]);
        pend_r = interp(hist[hi+1], hist[hi], fr);
        lw  = (int'(depth) * 256 - int'(mod_word)) & 16'hffff;
        lhi = lw >> 8; lfr = lw & 255;
        pend_l = interp(hist[lhi+1], hist[lhi], lfr);
        exp_addr[0] = wcount;
        exp_addr[1] = (wcount - hi - 1) & 16'hffff;
        exp_addr[2] = (wcount - hi) & 16'hffff;
        exp_addr[3] = (wcount - lhi - 1) & 16'hffff;
        exp_addr[4] = (wcount - lhi) & 16'hffff;
        exp_wdata = int'(in_left);
        ph = 1;
      end else if (ph == 6) begin
        ph = 0; exp_valid = 1; exp_l = pend_l; exp_r = pend_r;
      end else if (ph > 0) begin
        ph++;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && started) begin
      if (sram_we) writes++;
      if (sram_re) reads++;
      chk("R7 valid", int'(out_valid), int'(exp_valid));
      chk("R4 out_right", int'(out_right), int'(exp_r));
      chk("R5 out_left", int'(out_left), int'(exp_l));
      chk("R9 exclusive", int'(sram_we && sram_re), 0);
      case (ph)
        1: begin
          chk("R2 we", int'(sram_we), 1);
          chk("R2 waddr", int'(sram_addr), exp_addr[0]);
          chk("R2 wdata", int'(sram_wdata), exp_wdata);
        end
        2, 3: begin
          chk("R3 re", int'(sram_re), 1);
          chk("R3 raddr", int'(sram_addr), exp_addr[ph-1]);
        end
        4, 5: begin
          chk("R5 re", int'(sram_re), 1);
          chk("R5 raddr", int'(sram_addr), exp_addr[ph-1]);
        end
        default: chk("R9 idle bus", int'(sram_we | sram_re), 0);
      endcase
    end
  end

  task automatic send(logic [15:0] x, logic [15:0] m, logic [7:0] d, bit busy_poke);
    @(negedge clk);
    smp_stb = 1; in_left = x; mod_word = m; depth = d; in_right = 16'($urandom);
    sent++;
    @(negedge clk);
    smp_stb = 0;
    for (int k = 0; k < 7; k++) begin
      if (busy_poke && (k == 1 || k == 5)) begin
        smp_stb = 1; in_left = 16'($urandom); mod_word = 16'($urandom);
        depth = 8'($urandom); in_right = 16'($urandom);
      end else begin
        smp_stb = 0;
      end
      @(negedge clk);
    end
    smp_stb = 0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    for (int i = 0; i < 300; i++) hist.push_back(0);
    repeat (3) @(negedge clk);
    chk("R1 out_left", int'(out_left), 0);
    chk("R1 out_right", int'(out_right), 0);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 bus", int'(sram_we | sram_re), 0);
    rst = 0; started = 1;
    // first sample lands at address 1 (R1/R2 via per-cycle compare)
    // R6: no base delay
    for (int i = 0; i < 300; i++) begin
      logic [15:0] x;
      x = (i % 3 == 0) ? 16'h8000 : ((i % 3 == 1) ? 16'h7fff : 16'($urandom));
      send(x, 16'h0000, 8'h00, 0);
      chk("R6 right", int'(out_right), int'(interp(int'($signed(x)), int'($signed(x)), 0)));
      chk("R6 left", int'(out_left), int'(out_right));
    end
    // R4/R5: random modulation and depth
    for (int i = 0; i < 300; i++)
      send(16'($urandom), 16'($urandom), 8'($urandom), 0);
    // fraction extremes, full depth, modulation above depth span
    send(16'h1234, 16'h0500, 8'h10, 0);
    send(16'hfedc, 16'h05ff, 8'h10, 0);
    send(16'h4000, 16'h0000, 8'hff, 0);
    send(16'h8001, 16'hffff, 8'hff, 0);
    send(16'h0777, 16'hc0a5, 8'h20, 0);
    send(16'h7fff, 16'h00ff, 8'h00, 0);
    // R8: strobes during a busy sample are ignored
    for (int i = 0; i < 40; i++)
      send(16'($urandom), 16'($urandom), 8'($urandom), 1);
    repeat (4) @(negedge clk);
    chk("R8 writes", writes, sent);
    chk("R9 reads", reads, 4 * sent);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=timeout expected=done");
    summary();
    $finish;
  end
endmodule